// File: doc/BRIEF.md
# Open-Page Asynchronous DRAM Controller

This block sits between a simple host request port and an asynchronous page-mode DRAM that uses separate row and column strobes on one shared address bus. The host presents a request (address, write flag, write data) and holds it until the controller signals ready. The controller splits the flat address into a row part (upper bits) and a column part (lower bits). It sends the row address on the shared pins when the row strobe falls, and the column address when the column strobe falls.

After an access the row stays open, with the row strobe held low. A following request to the same row is served with a column cycle only. A request to a different row first closes the open row with a precharge and then opens the new one. A refresh timer requests one row-only refresh cycle per interval, stepping through all rows within a configurable window. A pending refresh blocks new host requests and closes any open row first. Read data is captured after the column strobe rises, which relies on the memory holding its output until the next column cycle.

Top module: `page_dram_ctrl`

## Requirements
- R1: After reset, the row strobe, column strobe and write enable are high, the data output enable and rd_valid are low, and req_ready is high.
- R2: When no row is open, a request drops the row strobe with the row address (address bits [ROW_W+COL_W-1:COL_W]) on the pins. At least T_RCD cycles later the column strobe drops with the column address (bits [COL_W-1:0]).
- R3: A request whose row equals the open row, with no refresh since the previous access, performs a column cycle without a new row activation.
- R4: The row strobe is high for at least T_RP cycles before every falling edge, including the precharge that closes an open row on a page miss.
- R5: The row strobe stays low for at least T_RAS cycles before it rises.
- R6: The column strobe is low for exactly T_CAS cycles per access and is only low while the row strobe is low.
- R7: During a write column cycle, write enable is low and the data output enable is high, with the request's write data on the data output. Write enable is never low outside a column cycle.
- R8: A read returns the addressed word on rd_data with a single-cycle rd_valid pulse, sampled after the column strobe has risen.
- R9: Refresh cycles drop the row strobe with the column strobe held high and the internal refresh row on the pins. The refresh row starts at 0 and increments by one per refresh, so every row is refreshed within REF_WINDOW cycles.
- R10: A pending refresh takes priority over new host requests, so refreshes keep their interval under continuous traffic. A refresh never starts inside a column cycle.
- R11: The first access after a refresh or reset is treated as a page miss and activates its row.
- R12: A request is accepted only in a cycle where req_valid and req_ready are both high. With req_valid low, no column cycle is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Flat word address, row in upper bits |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted this cycle when valid is high |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | DATA_W | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_out | output | DATA_W | Write data to memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Read data from memory |

## Verification
The hardest case to reach from the ports is a refresh timer expiry that coincides with a host request while a row is open and its minimum active time has not yet elapsed. In that case the controller must refuse the request, wait out the active time, precharge, refresh, and then treat the returned request as a miss. The random phase mixes zero-gap back-to-back traffic with short random gaps, so refresh expiries fall on every phase of an access. A memory model measures every strobe interval and the refresh spacing. Directed runs hold the bus busy continuously, then idle past a refresh interval and revisit the previously open row.

// File: rtl/page_dram_ctrl.sv
module page_dram_ctrl #(
  parameter int ROW_W      = 6,
  parameter int COL_W      = 5,
  parameter int DATA_W     = 16,
  parameter int T_RCD      = 2,
  parameter int T_RP       = 2,
  parameter int T_RAS      = 5,
  parameter int T_CAS      = 2,
  parameter int REF_WINDOW = 4096
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   req_ready,
  output logic                   rd_valid,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic [(ROW_W>COL_W?ROW_W:COL_W)-1:0] dram_addr,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);
  localparam int PIN_W      = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int ROWS       = 1 << ROW_W;
  localparam int REF_PERIOD = REF_WINDOW / ROWS;
  localparam int RT_W       = $clog2(REF_PERIOD + 1);
  localparam int CW         = 8;
  localparam int AW         = $clog2(T_RAS + 1);
  localparam int RAS_LIM    = T_RAS - 1;

  typedef enum logic [2:0] {S_IDLE, S_ACT, S_COL, S_PRE, S_REF} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic             open_vld, ref_pend, goto_ref, q_pend, q_we, cap_pend;
  logic [ROW_W-1:0] open_row, ref_row, q_row;
  logic [COL_W-1:0] q_col;
  logic [DATA_W-1:0] q_wdata;
  logic [RT_W-1:0]  ref_tmr;
  logic [AW-1:0]    ras_age;

  wire [ROW_W-1:0] req_row  = req_addr[ROW_W+COL_W-1:COL_W];
  wire [COL_W-1:0] req_col  = req_addr[COL_W-1:0];
  wire             hit      = open_vld && (req_row == open_row);
  wire             tras_ok  = ras_age >= AW'(RAS_LIM);
  wire             cnt_done = (cnt == '0);
  wire             acc      = req_valid && req_ready;

  assign req_ready   = (st == S_IDLE) && !ref_pend && (!open_vld || hit || tras_ok);
  assign dram_ras_n  = !((st == S_ACT) || (st == S_COL) || (st == S_REF) ||
                         (st == S_IDLE && open_vld));
  assign dram_cas_n  = (st != S_COL);
  assign dram_we_n   = !((st == S_COL) && q_we);
  assign dram_dq_oe  = (st == S_COL) && q_we;
  assign dram_dq_out = q_wdata;

  always_comb begin
    dram_addr = '0;
    case (st)
      S_ACT:   dram_addr = PIN_W'(open_row);
      S_REF:   dram_addr = PIN_W'(ref_row);
      S_COL:   dram_addr = PIN_W'(q_col);
      default: dram_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; open_vld <= 1'b0; open_row <= '0; ref_row <= '0;
      ref_pend <= 1'b0; ref_tmr <= '0; ras_age <= '0; goto_ref <= 1'b0;
      q_pend <= 1'b0; q_we <= 1'b0; q_row <= '0; q_col <= '0; q_wdata <= '0;
      cap_pend <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      rd_valid <= 1'b0;
      cap_pend <= 1'b0;
      if (cap_pend) begin
        rd_data  <= dram_dq_in;
        rd_valid <= 1'b1;
      end
      if (dram_ras_n) ras_age <= '0;
      else if (!tras_ok) ras_age <= ras_age + 1'b1;
      if (!cnt_done) cnt <= cnt - 1'b1;

      case (st)
        S_IDLE: begin
          if (ref_pend) begin
            if (!open_vld) begin
              st <= S_REF; cnt <= CW'(T_RAS - 1); ref_pend <= 1'b0;
            end else if (tras_ok) begin
              st <= S_PRE; cnt <= CW'(T_RP - 1); goto_ref <= 1'b1; open_vld <= 1'b0;
            end
          end else if (acc) begin
            q_we <= req_we; q_row <= req_row; q_col <= req_col; q_wdata <= req_wdata;
            if (hit) begin
              st <= S_COL; cnt <= CW'(T_CAS - 1);
            end else if (open_vld) begin
              st <= S_PRE; cnt <= CW'(T_RP - 1); open_vld <= 1'b0; q_pend <= 1'b1;
            end else begin
              st <= S_ACT; cnt <= CW'(T_RCD - 1); open_vld <= 1'b1; open_row <= req_row;
            end
          end
        end
        S_PRE: if (cnt_done) begin
          if (goto_ref) begin
            st <= S_REF; cnt <= CW'(T_RAS - 1); goto_ref <= 1'b0; ref_pend <= 1'b0;
          end else if (q_pend) begin
            st <= S_ACT; cnt <= CW'(T_RCD - 1); q_pend <= 1'b0;
            open_vld <= 1'b1; open_row <= q_row;
          end else st <= S_IDLE;
        end
        S_ACT: if (cnt_done) begin st <= S_COL; cnt <= CW'(T_CAS - 1); end
        S_COL: if (cnt_done) begin st <= S_IDLE; cap_pend <= !q_we; end
        S_REF: if (cnt_done) begin
          st <= S_PRE; cnt <= CW'(T_RP - 1); ref_row <= ref_row + 1'b1;
        end
        default: st <= S_IDLE;
      endcase

      if (ref_tmr == RT_W'(REF_PERIOD - 1)) begin
        ref_tmr <= '0; ref_pend <= 1'b1;
      end else ref_tmr <= ref_tmr + 1'b1;
    end
  end

  int hi_cnt, lo_cnt, cas_lo;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= T_RP; lo_cnt <= 0; cas_lo <= 0;
    end else begin
      hi_cnt <= dram_ras_n ? ((hi_cnt < 255) ? hi_cnt + 1 : hi_cnt) : 0;
      lo_cnt <= !dram_ras_n ? ((lo_cnt < 255) ? lo_cnt + 1 : lo_cnt) : 0;
      cas_lo <= !dram_cas_n ? ((cas_lo < 255) ? cas_lo + 1 : cas_lo) : 0;
    end
  end

  a_r4_precharge_time: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> hi_cnt >= T_RP) else $error("R4 precharge too short");
  a_r5_active_time: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> lo_cnt >= T_RAS) else $error("R5 row active too short");
  a_r6_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n) else $error("R6 column strobe without row");
  a_r6_cas_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_cas_n) |-> cas_lo == T_CAS) else $error("R6 column width");
  a_r7_we_in_col: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> (!dram_cas_n && dram_dq_oe)) else $error("R7 write enable outside column");
  a_r8_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid) else $error("R8 read pulse too long");
  a_r9_ref_ras_only: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_REF) |-> (dram_cas_n && !dram_ras_n)) else $error("R9 refresh not row-only");
endmodule

// File: tb/sim_page_dram_ctrl.sv
module sim_page_dram_ctrl;
  localparam int ROW_W = 4, COL_W = 4, DATA_W = 16;
  localparam int T_RCD = 2, T_RP = 3, T_RAS = 5, T_CAS = 2, REF_WINDOW = 1024;
  localparam int ROWS = 1 << ROW_W;
  localparam int WORDS = 1 << (ROW_W + COL_W);
  localparam int REF_PERIOD = REF_WINDOW / ROWS;
  localparam int PIN_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0, dq_in = '0;
  logic req_ready, rd_valid, ras_n, cas_n, we_n, dq_oe;
  logic [DATA_W-1:0] rd_data, dq_out;
  logic [PIN_W-1:0] addr;

  page_dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
    .T_RP(T_RP), .T_RAS(T_RAS), .T_CAS(T_CAS), .REF_WINDOW(REF_WINDOW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
    .dram_we_n(we_n), .dram_addr(addr), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe),
    .dram_dq_in(dq_in));

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] exp_mem [WORDS];
  int ref_time [ROWS];

  function automatic logic [DATA_W-1:0] init_word(int a);
    return DATA_W'((a * 40503) ^ 16'h5a5a);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc++;

  // memory model and strobe timing monitor
  logic prev_ras = 1'b1, prev_cas = 1'b1, cas_seen = 1'b0, last_new_act = 1'b0;
  int ras_lo = 0, ras_hi = 100, cas_lo = 0, op_done = 0, ref_cnt = 0, last_ref_at_cas = 0;
  int exp_ref_row = 0, last_ref_cyc = 0;
  logic [ROW_W-1:0] m_row = '0;
  int cur_row = 0, cur_col = 0;
  bit cur_we = 0;
  logic [DATA_W-1:0] cur_wdata = '0;

  always @(negedge clk) if (rst_n) begin
    if (prev_ras && !ras_n) begin
      check(ras_hi >= T_RP, "R4 precharge cycles", ras_hi, T_RP);
      m_row = addr[ROW_W-1:0]; cas_seen = 1'b0; ras_lo = 0;
    end
    if (!prev_ras && ras_n) begin
      check(ras_lo >= T_RAS, "R5 active cycles", ras_lo, T_RAS);
      if (!cas_seen) begin
        check(m_row == exp_ref_row[ROW_W-1:0], "R9 refresh row", m_row, exp_ref_row % ROWS);
        if (ref_cnt > 0)
          check(cyc - last_ref_cyc <= REF_PERIOD + 24, "R10 refresh spacing",
                cyc - last_ref_cyc, REF_PERIOD);
        exp_ref_row++; ref_cnt++; last_ref_cyc = cyc; ref_time[m_row] = cyc;
      end
      ras_hi = 0;
    end
    if (prev_cas && !cas_n) begin
      check(ras_lo >= T_RCD, "R2 row-to-column cycles", ras_lo, T_RCD);
      last_new_act = !cas_seen; cas_seen = 1'b1; last_ref_at_cas = ref_cnt;
      check(m_row == cur_row && addr[COL_W-1:0] == cur_col, "R2 address",
            {m_row, addr[COL_W-1:0]}, cur_row * (1 << COL_W) + cur_col);
      if (!we_n) begin
        check(dq_oe && dq_out == cur_wdata && cur_we, "R7 write data", dq_out, cur_wdata);
        mem[{m_row, addr[COL_W-1:0]}] = dq_out;
      end else begin
        check(!dq_oe && !cur_we, "R7 read no drive", dq_oe, 0);
        dq_in = mem[{m_row, addr[COL_W-1:0]}];
      end
      cas_lo = 0;
    end
    if (!prev_cas && cas_n) begin
      check(cas_lo == T_CAS, "R6 column width", cas_lo, T_CAS);
      op_done++;
    end
    if (!ras_n) ras_lo++; else ras_hi++;
    if (!cas_n) cas_lo++;
    prev_ras = ras_n; prev_cas = cas_n;
  end

  bit last_valid = 0;
  int last_row = 0, prev_ref = 0;

  task automatic do_op(input bit we, input int row, input int col, input logic [DATA_W-1:0] wd);
    int d0, n;
    bit exp_hit;
    @(negedge clk);
    cur_row = row; cur_col = col; cur_we = we; cur_wdata = wd;
    d0 = op_done;
    req_valid = 1'b1; req_we = we; req_addr = (ROW_W + COL_W)'(row * (1 << COL_W) + col);
    req_wdata = wd;
    #0.5;
    n = 0;
    while (!req_ready && n < 500) begin @(negedge clk); #0.5; n++; end
    @(negedge clk);
    req_valid = 1'b0;
    if (we) exp_mem[row * (1 << COL_W) + col] = wd;
    n = 0;
    while (op_done == d0 && n < 500) begin @(negedge clk); n++; end
    exp_hit = last_valid && row == last_row && last_ref_at_cas == prev_ref;
    if (exp_hit) check(!last_new_act, "R3 page hit no activation", last_new_act, 0);
    else if (last_ref_at_cas != prev_ref)
      check(last_new_act, "R11 miss after refresh", last_new_act, 1);
    else check(last_new_act, "R4 page miss activation", last_new_act, 1);
    last_valid = 1; last_row = row; prev_ref = last_ref_at_cas;
    if (!we) begin
      n = 0;
      while (!rd_valid && n < 50) begin @(negedge clk); n++; end
      check(rd_valid && rd_data == exp_mem[row * (1 << COL_W) + col], "R8 read data",
            rd_data, exp_mem[row * (1 << COL_W) + col]);
      @(negedge clk);
      check(!rd_valid, "R8 single pulse", rd_valid, 0);
    end
  endtask

  task automatic idle(input int k);
    int d0;
    d0 = op_done;
    for (int i = 0; i < k; i++) @(negedge clk);
    check(op_done == d0, "R12 no access without valid", op_done - d0, 0);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    for (int a = 0; a < WORDS; a++) begin mem[a] = init_word(a); exp_mem[a] = init_word(a); end
    for (int r = 0; r < ROWS; r++) ref_time[r] = 0;
    void'($urandom(32'h1bad5eed));
    #12 rst_n = 1'b1;
    @(negedge clk);
    check(ras_n && cas_n && we_n && !dq_oe && !rd_valid && req_ready, "R1 reset state",
          {ras_n, cas_n, we_n, dq_oe, rd_valid, req_ready}, 6'b111001);
    // directed: first access miss, hits, boundary addresses
    do_op(0, 3, 0, '0);
    do_op(1, 3, 15, 16'hbeef);
    do_op(0, 3, 15, '0);
    do_op(1, 15, 15, 16'h0123);
    do_op(0, 15, 15, '0);
    do_op(0, 0, 0, '0);
    // idle past a refresh, then revisit the same row
    idle(REF_PERIOD + 20);
    do_op(0, 0, 0, '0);
    // back-to-back hits through refresh expiries
    for (int i = 0; i < 60; i++) do_op(i[0], 5, i % 16, DATA_W'(i * 7 + 1));
    // random mix
    for (int i = 0; i < 260; i++) begin
      int row, col, gap;
      row = ($urandom % 3 == 0) ? int'($urandom % ROWS) : last_row;
      col = $urandom % (1 << COL_W);
      do_op($urandom % 2, row, col, DATA_W'($urandom));
      gap = $urandom % 7;
      if (gap > 0) idle(gap);
    end
    for (int a = 0; a < 8; a++) do_op(0, a, a, '0);
    for (int r = 0; r < ROWS; r++)
      check(cyc - ref_time[r] <= REF_WINDOW + 64, "R9 row refresh age", cyc - ref_time[r],
            REF_WINDOW);
    finish_run();
  end

  initial begin
    wait (cyc >= 150000);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    finish_run();
  end
endmodule